// File: doc/BRIEF.md
# Four-Mode Serial Port with Shared Interrupt

This block is the serial port of a small microcontroller. It has three byte-wide registers that the CPU reaches over a simple register bus: a control register, a data buffer and a power register. The control register selects one of four framing modes and carries the receive enable and the ninth data bits. It also holds two sticky completion flags: transmit done and receive done. Writing the data buffer starts a transmission on `txd`. Reading the data buffer returns the last byte that was received on `rxd`.

Bit timing comes from one of three sources, chosen by the mode:
- a fixed divide-by-12 of the system clock;
- the system clock divided by 32, or by 16 when the doubling bit is set;
- overflow pulses from an external timer, divided in the same way.

An external select makes the timer-clocked modes use a second timer's pulses with a fixed divide-by-16. Each direction has its own prescaler, so transmit and receive keep independent bit phases. The two completion flags are OR-ed into one interrupt request, which an external enable gates.

Top module: `mcu_serial_port`

## Requirements
- R1: After reset all three registers read 0x00, `txd` is high and `irq` is low.
- R2: The bus addresses are 0 for control, 1 for the data buffer and 2 for power. Control bits [7:6] give the mode and bit 5 is plain storage. Bit 4 is the receive enable, bit 3 is TB8, bit 2 is RB8, bit 1 is TI and bit 0 is RI. Power bit 7 is the baud-doubling bit. Control and power read back what was written.
- R3: Mode 0 shifts 8 data bits out on `txd`, least significant bit first, with no start or stop bit. Each bit lasts 12 clocks. TI rises at the 96th rising edge after the write edge.
- R4: Mode 2 counts system clocks with a divide of 32, or 16 when doubled. Its frame is 11 bits: a low start bit, 8 data bits LSB first, TB8, then a high stop bit. With a divide of 32, TI rises 352 clocks after the write.
- R5: Modes 1 and 3 count pulses on `t1_ovf`, 16 pulses per bit when doubled and 32 otherwise. A mode 1 frame is 10 bits: a low start bit, 8 data bits, then a high stop bit.
- R6: While `t2_baud_sel` is high, modes 1 and 3 count `t2_ovf` pulses at 16 per bit whatever the doubling bit says. A rise of `t2_baud_sel` clears both prescalers.
- R7: A write to the data buffer loads the byte and restarts the frame from its first bit, with the bit and prescaler counts cleared. This holds even while a frame is still being sent.
- R8: TI is set when a frame has been sent. TI and RI are cleared only by control register writes. If a control write lands in the same cycle as a hardware flag set, the flag ends up set.
- R9: In modes 1 to 3, with receive enable set and the receiver idle, a falling edge on `rxd` starts a frame. Each bit is sampled at mid-bit. At the end of the frame the byte goes into the read side of the data buffer and RI is set. In modes 2 and 3 the ninth bit is also copied into RB8.
- R10: While receive enable is clear, traffic on `rxd` leaves the data buffer and RI unchanged.
- R11: In mode 0, reception starts when receive enable is set and RI is clear. It samples 8 bits from `rxd`, LSB first, one every 12 clocks, with the first sample 7 clocks after the start.
- R12: `irq` is high exactly when `ser_int_en` is high and TI or RI is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| t1_ovf | input | 1 | Timer-1 overflow pulse |
| t2_ovf | input | 1 | Timer-2 overflow pulse |
| t2_baud_sel | input | 1 | Use timer-2 as the baud source |
| ser_int_en | input | 1 | Serial interrupt enable |
| rxd | input | 1 | Serial data in |
| txd | output | 1 | Serial data out |
| irq | output | 1 | Combined serial interrupt request |

## Verification
A software write to the control register can fall in the same clock as the hardware setting TI at the end of a frame. In mode 0 the frame end falls on a known edge, 96 clocks after the buffer write. The bench places a control write of 0x00 exactly on that edge, then reads TI back. TI must read as set, and a second control write must then clear it.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT     = 2'd0,
        MODE_ASYNC8    = 2'd1,
        MODE_ASYNC9_FX = 2'd2,
        MODE_ASYNC9_TM = 2'd3
    } sp_mode_e;

    localparam int CTL_RI  = 0;
    localparam int CTL_TI  = 1;
    localparam int CTL_RB8 = 2;
    localparam int CTL_TB8 = 3;
    localparam int CTL_REN = 4;
    localparam int PWR_DBL = 7;
    localparam int CNT_W   = 4;

    // number of bit times in one frame of the given mode
    function automatic logic [CNT_W-1:0] frame_len(input sp_mode_e m);
        case (m)
            MODE_SHIFT:  return 4'd8;
            MODE_ASYNC8: return 4'd10;
            default:     return 4'd11;
        endcase
    endfunction

endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_evt,
    input  logic [PRE_W-1:0] div,
    output logic             half_tick,
    output logic             full_tick
);
    localparam logic [PRE_W-1:0] ONE = 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } baud_st_t;

    baud_st_t q, d;
    logic [PRE_W-1:0] half_pt;

    assign half_pt = (div >> 1) - ONE;

    always_comb begin
        d         = q;
        half_tick = 1'b0;
        full_tick = 1'b0;
        if (clr) begin
            d.pre = '0;
        end else if (src_evt) begin
            half_tick = (q.pre == half_pt);
            if (q.pre == div - ONE) begin
                full_tick = 1'b1;
                d.pre     = '0;
            end else begin
                d.pre = q.pre + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: a clear request restarts the prescaler
    a_r6_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.pre == '0));
    // R3: a completed bit period wraps the count
    a_r3_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        full_tick |=> (q.pre == '0));

endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic [7:0] data,
    input  logic     ninth,
    input  sp_mode_e mode,
    input  logic     full_tick,
    output logic     txd,
    output logic     done
);
    typedef struct packed {
        logic             busy;
        sp_mode_e         mode;
        logic [CNT_W-1:0] cnt;
        logic [10:0]      frame;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.mode = mode;
            case (mode)
                MODE_SHIFT:  d.frame = {3'b111, data};
                MODE_ASYNC8: d.frame = {2'b11, data, 1'b0};
                default:     d.frame = {1'b1, ninth, data, 1'b0};
            endcase
        end else if (q.busy && full_tick) begin
            if (q.cnt == frame_len(q.mode) - 4'd1) begin
                done    = 1'b1;
                d.busy  = 1'b0;
                d.frame = '1;
            end else begin
                d.cnt   = q.cnt + 4'd1;
                d.frame = {1'b1, q.frame[10:1]};
            end
        end
    end

    assign txd = q.busy ? q.frame[0] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy  <= 1'b0;
            q.mode  <= MODE_SHIFT;
            q.cnt   <= '0;
            q.frame <= '1;
        end else begin
            q <= d;
        end
    end

    // R7: a buffer write restarts the frame at bit zero
    a_r7_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.busy && q.cnt == '0));
    // R8: frame end releases the transmitter
    a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !q.busy);

endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sp_mode_e   mode,
    input  logic       en,
    input  logic       ri,
    input  logic       rxd,
    input  logic       half_tick,
    input  logic       full_tick,
    output logic       start,
    output logic       done,
    output logic [7:0] data,
    output logic       ninth
);
    typedef struct packed {
        logic             busy;
        sp_mode_e         mode;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       data;
        logic             ninth;
        logic             rxd_q;
    } rx_st_t;

    rx_st_t q, d;
    logic [CNT_W-1:0] km1;

    assign km1 = q.cnt - 4'd1;

    always_comb begin
        d       = q;
        d.rxd_q = rxd;
        done    = 1'b0;
        if (mode == MODE_SHIFT) start = !q.busy && en && !ri;
        else                    start = !q.busy && en && q.rxd_q && !rxd;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.mode = mode;
        end else if (q.busy) begin
            if (half_tick) begin
                if (q.mode == MODE_SHIFT)
                    d.data[q.cnt[2:0]] = rxd;
                else if (q.cnt >= 4'd1 && q.cnt <= 4'd8)
                    d.data[km1[2:0]] = rxd;
                else if (q.cnt == 4'd9 && q.mode[1])
                    d.ninth = rxd;
            end
            if (full_tick) begin
                if (q.cnt == frame_len(q.mode) - 4'd1) begin
                    done   = 1'b1;
                    d.busy = 1'b0;
                end else begin
                    d.cnt = q.cnt + 4'd1;
                end
            end
        end
    end

    assign data  = q.data;
    assign ninth = q.ninth;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy  <= 1'b0;
            q.mode  <= MODE_SHIFT;
            q.cnt   <= '0;
            q.data  <= '0;
            q.ninth <= 1'b0;
            q.rxd_q <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R9: the bit index stays inside the latched frame length
    a_r9_cnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt < frame_len(q.mode)));
    // R10: an idle receiver stays idle while disabled
    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !q.busy) |=> !q.busy);

endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port
    import sp_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       t1_ovf,
    input  logic       t2_ovf,
    input  logic       t2_baud_sel,
    input  logic       ser_int_en,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam logic [1:0]       ADDR_CTL = 2'd0;
    localparam logic [1:0]       ADDR_BUF = 2'd1;
    localparam logic [1:0]       ADDR_PWR = 2'd2;
    localparam logic [PRE_W-1:0] DIV_FIX  = 12;
    localparam logic [PRE_W-1:0] DIV_FAST = 16;
    localparam logic [PRE_W-1:0] DIV_SLOW = 32;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] pwr;
        logic [7:0] rbuf;
        logic       t2sel;
    } top_st_t;

    top_st_t q, d;

    sp_mode_e         mode;
    logic             dbl, t2_rise, src_evt;
    logic [PRE_W-1:0] div;
    logic             tx_start, tx_done, tx_half, tx_full;
    logic             rx_start, rx_done, rx_half, rx_full, rx_ninth;
    logic [7:0]       rx_data;

    assign mode    = sp_mode_e'(q.ctrl[7:6]);
    assign dbl     = q.pwr[PWR_DBL];
    assign t2_rise = t2_baud_sel && !q.t2sel;
    assign tx_start = bus_wr && (bus_addr == ADDR_BUF);

    // baud source and divider by mode
    always_comb begin
        case (mode)
            MODE_SHIFT: begin
                src_evt = 1'b1;
                div     = DIV_FIX;
            end
            MODE_ASYNC9_FX: begin
                src_evt = 1'b1;
                div     = dbl ? DIV_FAST : DIV_SLOW;
            end
            default: begin
                src_evt = t2_baud_sel ? t2_ovf : t1_ovf;
                div     = (t2_baud_sel || dbl) ? DIV_FAST : DIV_SLOW;
            end
        endcase
    end

    sp_baud #(.PRE_W(PRE_W)) u_tx_baud (
        .clk(clk), .rst_n(rst_n), .clr(tx_start || t2_rise), .src_evt(src_evt),
        .div(div), .half_tick(tx_half), .full_tick(tx_full)
    );

    sp_baud #(.PRE_W(PRE_W)) u_rx_baud (
        .clk(clk), .rst_n(rst_n), .clr(rx_start || t2_rise), .src_evt(src_evt),
        .div(div), .half_tick(rx_half), .full_tick(rx_full)
    );

    sp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(bus_wdata),
        .ninth(q.ctrl[CTL_TB8]), .mode(mode), .full_tick(tx_full),
        .txd(txd), .done(tx_done)
    );

    sp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .en(q.ctrl[CTL_REN]),
        .ri(q.ctrl[CTL_RI]), .rxd(rxd), .half_tick(rx_half), .full_tick(rx_full),
        .start(rx_start), .done(rx_done), .data(rx_data), .ninth(rx_ninth)
    );

    always_comb begin
        d       = q;
        d.t2sel = t2_baud_sel;
        if (bus_wr && bus_addr == ADDR_CTL) d.ctrl = bus_wdata;
        if (bus_wr && bus_addr == ADDR_PWR) d.pwr  = bus_wdata;
        // hardware flag sets take priority over a same-cycle software write
        if (tx_done) d.ctrl[CTL_TI] = 1'b1;
        if (rx_done) begin
            d.ctrl[CTL_RI] = 1'b1;
            d.rbuf         = rx_data;
            if (mode == MODE_ASYNC9_FX || mode == MODE_ASYNC9_TM)
                d.ctrl[CTL_RB8] = rx_ninth;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTL: bus_rdata = q.ctrl;
            ADDR_BUF: bus_rdata = q.rbuf;
            ADDR_PWR: bus_rdata = q.pwr;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq = ser_int_en && (q.ctrl[CTL_TI] || q.ctrl[CTL_RI]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: flags are sticky unless software writes the control register
    a_r8_ti_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl[CTL_TI] && !(bus_wr && bus_addr == ADDR_CTL)) |=> q.ctrl[CTL_TI]);
    a_r8_ri_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl[CTL_RI] && !(bus_wr && bus_addr == ADDR_CTL)) |=> q.ctrl[CTL_RI]);
    // R8: end of a transmitted frame always leaves TI set
    a_r8_ti_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> q.ctrl[CTL_TI]);
    // R9: the read side of the buffer only changes when a frame completes
    a_r9_rbuf_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(q.rbuf));

endmodule

// File: tb/test_mcu_serial_port.sv
module test_mcu_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       t1_ovf = 1'b0, t2_ovf = 1'b0, t2_baud_sel = 1'b0;
    logic       ser_int_en = 1'b0, rxd = 1'b1;
    logic       txd, irq;
    logic       t1_on = 1'b0, t2_on = 1'b0;
    logic [1:0] t1_ph = 2'd0, t2_ph = 2'd0;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    mcu_serial_port i_mcu_serial_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .t1_ovf(t1_ovf),
        .t2_ovf(t2_ovf), .t2_baud_sel(t2_baud_sel), .ser_int_en(ser_int_en),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    // timer pulse generators: timer-1 every 4 clocks, timer-2 every 3 clocks
    always @(negedge clk) begin
        t1_ph  <= t1_ph + 2'd1;
        t1_ovf <= t1_on && (t1_ph == 2'd3);
        t2_ph  <= (t2_ph == 2'd2) ? 2'd0 : t2_ph + 2'd1;
        t2_ovf <= t2_on && (t2_ph == 2'd2);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_ti(input int lim, inout int n);
        logic [7:0] v;
        for (int i = 0; i < lim; i++) begin
            rd(2'd0, v);
            if (v[1]) return;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic send(input logic [10:0] bits, input int nb, input int per);
        for (int i = 0; i < nb; i++) begin
            rxd = bits[i];
            repeat (per) @(negedge clk);
        end
        rxd = 1'b1;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], v);
            chk("R1 register after reset", v, 8'h00);
        end
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 irq low", irq, 1'b0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(2'd0, 8'hE8); rd(2'd0, v); chk("R2 control readback", v, 8'hE8);
        wr(2'd2, 8'h80); rd(2'd2, v); chk("R2 power readback", v, 8'h80);
        wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_mode0_tx;
        logic [7:0] v;
        wr(2'd1, 8'h5A);
        repeat (6) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            chk("R3 shift bit", txd, 1'((8'h5A >> k) & 8'h01));
            if (k < 7) repeat (12) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R3 TI not yet at edge 95", v[1], 1'b0);
        @(negedge clk);
        rd(2'd0, v); chk("R3 TI at edge 96", v[1], 1'b1);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h33);
        repeat (95) @(negedge clk);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R8 hardware set wins same-cycle write", v, 8'h02);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R8 software write clears TI", v, 8'h00);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        wr(2'd1, 8'hFF);
        repeat (30) @(negedge clk);
        wr(2'd1, 8'h00);
        repeat (6) @(negedge clk);
        chk("R7 restarted frame bit 0", txd, 1'b0);
        repeat (89) @(negedge clk);
        rd(2'd0, v); chk("R7 no TI before restarted frame ends", v[1], 1'b0);
        @(negedge clk);
        rd(2'd0, v); chk("R7 TI at end of restarted frame", v[1], 1'b1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_mode2_tx;
        logic [7:0]  v;
        logic [10:0] f;
        f = {1'b1, 1'b1, 8'h3C, 1'b0};
        wr(2'd0, 8'h88);
        wr(2'd1, 8'h3C);
        repeat (16) @(negedge clk);
        for (int k = 0; k < 11; k++) begin
            chk("R4 mode 2 frame bit", txd, f[k]);
            if (k < 10) repeat (32) @(negedge clk);
        end
        repeat (15) @(negedge clk);
        rd(2'd0, v); chk("R4 TI not yet at edge 351", v[1], 1'b0);
        @(negedge clk);
        rd(2'd0, v); chk("R4 TI at edge 352", v[1], 1'b1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_mode1_tx;
        logic [9:0] f;
        int n;
        f = {1'b1, 8'h96, 1'b0};
        t1_on = 1'b1;
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h40);
        wr(2'd1, 8'h96);
        repeat (32) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            chk("R5 mode 1 frame bit", txd, f[k]);
            if (k < 9) repeat (64) @(negedge clk);
        end
        n = 608;
        wait_ti(100, n);
        chk("R5 frame length near 640 clocks", (n >= 630 && n <= 645), 1'b1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_t2_tx;
        int n;
        t2_on = 1'b1;
        wr(2'd2, 8'h00);
        t2_baud_sel = 1'b1;
        @(negedge clk);
        wr(2'd0, 8'hC0);
        wr(2'd1, 8'h0F);
        repeat (24) @(negedge clk);
        chk("R6 start bit with timer-2 source", txd, 1'b0);
        n = 24;
        wait_ti(700, n);
        chk("R6 timer-2 divide by 16 frame near 528 clocks", (n >= 520 && n <= 535), 1'b1);
        t2_baud_sel = 1'b0;
        wr(2'd0, 8'h00);
    endtask

    task automatic t_rx_mode2;
        logic [7:0] v;
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h90);
        repeat (4) @(negedge clk);
        send({1'b1, 1'b1, 8'hA5, 1'b0}, 11, 16);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R9 RI and RB8 set in mode 2", v, 8'h95);
        rd(2'd1, v); chk("R9 received byte", v, 8'hA5);
    endtask

    task automatic t_rx_off;
        logic [7:0] v;
        wr(2'd0, 8'h80);
        repeat (4) @(negedge clk);
        send({1'b1, 1'b0, 8'h3C, 1'b0}, 11, 16);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R10 RI stays clear without enable", v, 8'h80);
        rd(2'd1, v); chk("R10 buffer unchanged", v, 8'hA5);
    endtask

    task automatic t_rx_mode1;
        logic [7:0] v;
        wr(2'd0, 8'h50);
        repeat (4) @(negedge clk);
        send({1'b0, 1'b1, 8'h66, 1'b0}, 10, 64);
        repeat (8) @(negedge clk);
        rd(2'd0, v); chk("R9 mode 1 RI set, RB8 untouched", v, 8'h51);
        rd(2'd1, v); chk("R9 mode 1 byte", v, 8'h66);
    endtask

    task automatic t_rx_mode0;
        logic [7:0] v;
        wr(2'd0, 8'h10);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = 1'((8'hC3 >> k) & 8'h01);
            repeat (12) @(negedge clk);
        end
        rxd = 1'b1;
        rd(2'd0, v); chk("R11 mode 0 RI set", v, 8'h11);
        rd(2'd1, v); chk("R11 mode 0 byte", v, 8'hC3);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_irq;
        wr(2'd0, 8'h02);
        ser_int_en = 1'b0; #1;
        chk("R12 irq gated off", irq, 1'b0);
        ser_int_en = 1'b1; #1;
        chk("R12 irq with TI", irq, 1'b1);
        @(negedge clk);
        wr(2'd0, 8'h00); #1;
        chk("R12 irq drops with flags", irq, 1'b0);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mode0_tx();
        t_collision();
        t_restart();
        t_mode2_tx();
        t_mode1_tx();
        t_t2_tx();
        t_rx_mode2();
        t_rx_off();
        t_rx_mode1();
        t_rx_mode0();
        t_irq();
        summary();
        $finish;
    end

endmodule